// File: doc/BRIEF.md
# DS3 Alarm Indication Signal Detector

The block watches a receive DS3 bit stream that an upstream framer has already aligned. It raises `ais_alarm` once the line has carried the standard alarm indication signal for a long enough run of M-frames. An M-frame passes when three things hold at once. Every payload bit follows an alternating one-zero pattern. Every C-bit is zero. Both X-bits are one. The block keeps its own position inside the M-frame, and the `mframe_start` pulse snaps that position back to the first bit. Each M-frame is judged on its final bit.

A state machine turns the per-frame verdicts into the alarm. Its four states are IDLE, ARMING, ALARM and RELEASING.

IDLE moves to ARMING on a passing frame. ARMING counts passing frames and moves to ALARM when the count reaches `SET_FRAMES`. A failing frame in ARMING sends it back to IDLE.

ALARM moves to RELEASING on a frame whose payload breaks the pattern. RELEASING counts such frames and returns to IDLE when the count reaches `CLEAR_FRAMES`. A frame with an intact payload in RELEASING returns it to ALARM.

The alarm is high in ALARM and RELEASING. A threshold of 1 skips the counting state.

Top module: `ds3_ais_detect`

## Requirements
- R1: While reset is low and after it is released, `ais_alarm` is 0 until a qualifying run has completed.
- R2: A payload bit is the n-th bit after an overhead bit, n = 1..BLOCK_BITS-1. Its expected value is 1 for odd n and 0 for even n. One wrong payload bit disqualifies the M-frame.
- R3: The overhead bits at block indices 2, 4 and 6 of every subframe are C-bits. Block indices count from 0 inside the 8 blocks of a subframe. A C-bit equal to 1 disqualifies the M-frame.
- R4: The overhead bit at block index 0 of subframes 0 and 1 is an X-bit and must be 1. A 0 there disqualifies the frame. All other overhead bits (the F, M and P positions) have no effect on the verdict.
- R5: `ais_alarm` rises in the clock cycle after the last bit of the SET_FRAMES-th consecutive qualifying M-frame, and not earlier.
- R6: A disqualified M-frame before the alarm is raised restarts the qualifying count from zero.
- R7: While the alarm is raised, it falls in the cycle after the last bit of the CLEAR_FRAMES-th consecutive M-frame whose payload breaks the pattern. A frame with an intact payload restarts this count, even if its overhead bits are wrong.
- R8: `mframe_start` on a bit makes that bit position 0 of a new M-frame. A partly received frame cut short this way yields no verdict and leaves both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| rx_bit | input | 1 | Received serial bit |
| mframe_start | input | 1 | High on the first bit of an M-frame |
| ais_alarm | output | 1 | Alarm indication detected |

## Verification
The bench drives short frames, meaning a small block length, and drives the thresholds down. It compares the alarm against a behavioural model on every bit.

The first target is the exact rise cycle. An off-by-one in the qualifying count would raise the alarm one frame early or late.

It corrupts a single payload bit, a single C-bit and a single X-bit in separate runs. A detector that ignored any of these would raise the alarm where it must stay low. It also flips the F and M bits and expects the alarm anyway. This catches a detector that checks too many overhead bits.

During clearing, it inserts a frame with an intact payload but a wrong C-bit. A design that counted full disqualification instead of payload mismatch would release early. Finally, a frame cut short by a new start pulse must leave the counts alone. A design that judged the fragment would break the run.

// File: rtl/ais_pkg.sv
package ais_pkg;
    localparam int BLOCKS_PER_SF = 8;
    localparam int SUBFRAMES     = 7;
    localparam int BLK_W         = 3;
    localparam int SF_W          = 3;
    localparam int X_SUBFRAMES   = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMING,
        ST_ALARM,
        ST_RELEASING
    } ais_state_e;
endpackage

// File: rtl/ais_position_counter.sv
module ais_position_counter
    import ais_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    localparam int BW = $clog2(BLOCK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    output logic [BW-1:0]    bit_idx,
    output logic [BLK_W-1:0] blk_idx,
    output logic [SF_W-1:0]  sf_idx,
    output logic             last_bit
);
    logic [BW-1:0]    bit_q;
    logic [BLK_W-1:0] blk_q;
    logic [SF_W-1:0]  sf_q;

    always_comb begin
        if (frame_start) begin
            bit_idx = '0;
            blk_idx = '0;
            sf_idx  = '0;
        end else begin
            bit_idx = bit_q;
            blk_idx = blk_q;
            sf_idx  = sf_q;
        end
        last_bit = (bit_idx == BW'(BLOCK_BITS - 1)) &&
                   (blk_idx == BLK_W'(BLOCKS_PER_SF - 1)) &&
                   (sf_idx  == SF_W'(SUBFRAMES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            blk_q <= '0;
            sf_q  <= '0;
        end else if (bit_idx == BW'(BLOCK_BITS - 1)) begin
            bit_q <= '0;
            if (blk_idx == BLK_W'(BLOCKS_PER_SF - 1)) begin
                blk_q <= '0;
                sf_q  <= (sf_idx == SF_W'(SUBFRAMES - 1)) ? '0 : sf_idx + 1'b1;
            end else begin
                blk_q <= blk_idx + 1'b1;
                sf_q  <= sf_idx;
            end
        end else begin
            bit_q <= bit_idx + 1'b1;
            blk_q <= blk_idx;
            sf_q  <= sf_idx;
        end
    end

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |=> (bit_q == '0 && blk_q == '0 && sf_q == '0));

    p_bit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < BW'(BLOCK_BITS));
endmodule

// File: rtl/ais_frame_checker.sv
module ais_frame_checker
    import ais_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    localparam int BW = $clog2(BLOCK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             frame_start,
    input  logic [BW-1:0]    bit_idx,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [SF_W-1:0]  sf_idx,
    input  logic             last_bit,
    output logic             frame_done,
    output logic             full_ok,
    output logic             pay_ok
);
    logic acc_full_q, acc_pay_q;
    logic run_full, run_pay;
    logic is_oh, is_x, is_c, oh_good, bit_pay_good, bit_full_good;

    always_comb begin
        is_oh = (bit_idx == '0);
        is_x  = (blk_idx == '0) && (sf_idx < SF_W'(X_SUBFRAMES));
        is_c  = (blk_idx == BLK_W'(2)) || (blk_idx == BLK_W'(4)) ||
                (blk_idx == BLK_W'(6));
        if (is_x)      oh_good = rx_bit;
        else if (is_c) oh_good = !rx_bit;
        else           oh_good = 1'b1;
        bit_pay_good  = is_oh ? 1'b1 : (rx_bit == bit_idx[0]);
        bit_full_good = is_oh ? oh_good : bit_pay_good;
        run_full = (frame_start ? 1'b1 : acc_full_q) & bit_full_good;
        run_pay  = (frame_start ? 1'b1 : acc_pay_q) & bit_pay_good;
        frame_done = last_bit;
        full_ok    = last_bit & run_full;
        pay_ok     = last_bit & run_pay;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_full_q <= 1'b1;
            acc_pay_q  <= 1'b1;
        end else if (last_bit) begin
            acc_full_q <= 1'b1;
            acc_pay_q  <= 1'b1;
        end else begin
            acc_full_q <= run_full;
            acc_pay_q  <= run_pay;
        end
    end

    p_full_needs_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full_ok |-> pay_ok);

    p_verdict_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_ok || pay_ok) |-> frame_done);
endmodule

// File: rtl/ais_alarm_fsm.sv
module ais_alarm_fsm
    import ais_pkg::*;
#(
    parameter int SET_FRAMES   = 63,
    parameter int CLEAR_FRAMES = 4,
    localparam int MAXT = (SET_FRAMES > CLEAR_FRAMES) ? SET_FRAMES : CLEAR_FRAMES,
    localparam int CW   = $clog2(MAXT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic full_ok,
    input  logic pay_ok,
    output logic ais_alarm
);
    ais_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cnt_inc = cnt_q + 1'b1;
        if (frame_done) begin
            unique case (state_q)
                ST_IDLE: if (full_ok) begin
                    state_d = (SET_FRAMES == 1) ? ST_ALARM : ST_ARMING;
                    cnt_d   = (SET_FRAMES == 1) ? '0 : CW'(1);
                end
                ST_ARMING: if (!full_ok) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_inc == CW'(SET_FRAMES)) begin
                    state_d = ST_ALARM;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
                ST_ALARM: if (!pay_ok) begin
                    state_d = (CLEAR_FRAMES == 1) ? ST_IDLE : ST_RELEASING;
                    cnt_d   = (CLEAR_FRAMES == 1) ? '0 : CW'(1);
                end
                ST_RELEASING: if (pay_ok) begin
                    state_d = ST_ALARM;
                    cnt_d   = '0;
                end else if (cnt_inc == CW'(CLEAR_FRAMES)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ALARM, ST_RELEASING: ais_alarm = 1'b1;
            default:                ais_alarm = 1'b0;
        endcase
    end

    p_rise_after_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_alarm) |-> $past(frame_done && full_ok));

    p_fall_after_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ais_alarm) |-> $past(frame_done && !pay_ok));

    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(ais_alarm));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXT));
endmodule

// File: rtl/ds3_ais_detect.sv
module ds3_ais_detect
    import ais_pkg::*;
#(
    parameter int BLOCK_BITS   = 85,
    parameter int SET_FRAMES   = 63,
    parameter int CLEAR_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic mframe_start,
    output logic ais_alarm
);
    localparam int BW = $clog2(BLOCK_BITS);

    logic [BW-1:0]    bit_idx;
    logic [BLK_W-1:0] blk_idx;
    logic [SF_W-1:0]  sf_idx;
    logic             last_bit, frame_done, full_ok, pay_ok;

    ais_position_counter #(.BLOCK_BITS(BLOCK_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .frame_start(mframe_start),
        .bit_idx(bit_idx), .blk_idx(blk_idx), .sf_idx(sf_idx),
        .last_bit(last_bit)
    );

    ais_frame_checker #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .frame_start(mframe_start),
        .bit_idx(bit_idx), .blk_idx(blk_idx), .sf_idx(sf_idx),
        .last_bit(last_bit), .frame_done(frame_done),
        .full_ok(full_ok), .pay_ok(pay_ok)
    );

    ais_alarm_fsm #(.SET_FRAMES(SET_FRAMES), .CLEAR_FRAMES(CLEAR_FRAMES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .full_ok(full_ok), .pay_ok(pay_ok), .ais_alarm(ais_alarm)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_alarm) |-> $past(last_bit));
endmodule

// File: tb/test_ds3_ais_detect.sv
module test_ds3_ais_detect;
    localparam int BB    = 5;
    localparam int SETN  = 6;
    localparam int CLRN  = 3;
    localparam int FRAME = BB * 8 * 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic mframe_start = 1'b0;
    logic ais_alarm;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    int m_pos = 0, m_g = 0, m_b = 0;
    bit m_accf = 1, m_accp = 1, m_alarm = 0;

    always #10 clk = ~clk;

    ds3_ais_detect #(.BLOCK_BITS(BB), .SET_FRAMES(SETN), .CLEAR_FRAMES(CLRN)) i_ds3_ais_detect (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .mframe_start(mframe_start), .ais_alarm(ais_alarm)
    );

    task automatic compare(input logic exp, input string req);
        checks++;
        if (ais_alarm !== exp) begin
            errors++;
            $display("FAIL %s alarm actual %b expected %b at %0t", req, ais_alarm, exp, $time);
        end
    endtask

    // kind: 0 clean, 1 payload error, 2 C-bit set, 3 X-bit cleared,
    // 4 F/M bits flipped, 5 all-ones payload
    function automatic logic gen_bit(int p, int kind);
        int b, blk, sf;
        logic v;
        b = p % BB; blk = (p / BB) % 8; sf = p / (BB * 8);
        if (b == 0) begin
            if (blk == 0 && sf < 2) v = 1'b1;
            else v = 1'b0;
            if (kind == 2 && sf == 4 && blk == 4) v = 1'b1;
            if (kind == 3 && sf == 1 && blk == 0) v = 1'b0;
            if (kind == 4 && (blk % 2 == 1 || (blk == 0 && sf >= 2))) v = 1'b1;
        end else begin
            v = (b % 2 == 1);
            if (kind == 1 && sf == 3 && blk == 5 && b == 3) v = ~v;
            if (kind == 5) v = 1'b1;
        end
        return v;
    endfunction

    task automatic step(input logic b, input logic fs);
        int bi, blk, sf;
        bit good_f, good_p;
        @(negedge clk);
        compare(m_alarm, cur_req);
        rx_bit = b;
        mframe_start = fs;
        if (fs) begin m_pos = 0; m_accf = 1; m_accp = 1; end
        bi = m_pos % BB; blk = (m_pos / BB) % 8; sf = m_pos / (BB * 8);
        if (bi == 0) begin
            good_p = 1;
            if (blk == 0 && sf < 2) good_f = (b == 1'b1);
            else if (blk == 2 || blk == 4 || blk == 6) good_f = (b == 1'b0);
            else good_f = 1;
        end else begin
            good_p = (b == ((bi % 2) == 1));
            good_f = good_p;
        end
        m_accf = m_accf & good_f;
        m_accp = m_accp & good_p;
        if (m_pos == FRAME - 1) begin
            if (!m_alarm) begin
                if (m_accf) begin
                    m_g++;
                    if (m_g == SETN) begin m_alarm = 1; m_b = 0; end
                end else m_g = 0;
            end else begin
                if (!m_accp) begin
                    m_b++;
                    if (m_b == CLRN) begin m_alarm = 0; m_g = 0; end
                end else m_b = 0;
            end
            m_accf = 1; m_accp = 1;
            m_pos = 0;
        end else m_pos++;
    endtask

    task automatic send_frame(input int kind);
        for (int p = 0; p < FRAME; p++) step(gen_bit(p, kind), p == 0);
    endtask

    task automatic send_partial(input int kind, input int n);
        for (int p = 0; p < n; p++) step(gen_bit(p, kind), p == 0);
    endtask

    task automatic check_now(input logic exp, input string req);
        @(posedge clk);
        #2;
        compare(exp, req);
    endtask

    task automatic clear_alarm();
        cur_req = "R7";
        for (int i = 0; i < CLRN; i++) send_frame(5);
        check_now(1'b0, "R7");
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(1'b0, "R1");
        rst_n = 1'b1;
        check_now(1'b0, "R1");

        // R5: rise exactly after the SETN-th clean frame
        cur_req = "R5";
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        check_now(1'b0, "R5");
        send_frame(0);
        check_now(1'b1, "R5");

        // R7: intact payload restarts clear count, wrong C-bit does not release
        cur_req = "R7";
        send_frame(5); send_frame(5); send_frame(0);
        send_frame(5); send_frame(5); send_frame(2);
        send_frame(5); send_frame(5);
        check_now(1'b1, "R7");
        send_frame(5);
        check_now(1'b0, "R7");

        // R2 and R6: a single payload error restarts the qualifying run
        cur_req = "R6";
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        send_frame(1);
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        check_now(1'b0, "R2");
        send_frame(0);
        check_now(1'b1, "R6");
        clear_alarm();

        // R3: wrong C-bit disqualifies
        cur_req = "R3";
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        send_frame(2);
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        check_now(1'b0, "R3");
        send_frame(0);
        check_now(1'b1, "R3");
        clear_alarm();

        // R4: wrong X-bit disqualifies
        cur_req = "R4";
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        send_frame(3);
        check_now(1'b0, "R4");
        for (int i = 0; i < SETN - 1; i++) send_frame(0);
        check_now(1'b0, "R4");
        send_frame(0);
        check_now(1'b1, "R4");
        clear_alarm();

        // R4: F and M bits are ignored
        cur_req = "R4";
        for (int i = 0; i < SETN; i++) send_frame(4);
        check_now(1'b1, "R4");
        clear_alarm();

        // R8: a frame cut short by a new start pulse gives no verdict
        cur_req = "R8";
        for (int i = 0; i < 3; i++) send_frame(0);
        send_partial(5, 137);
        for (int i = 0; i < 2; i++) send_frame(0);
        check_now(1'b0, "R8");
        send_frame(0);
        check_now(1'b1, "R8");
        send_partial(0, 60);
        clear_alarm();

        step(1'b0, 1'b0);
        check_now(1'b0, "R1");
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule